// File: doc/BRIEF.md
# I2C SCL Bit-Timing Generator

This block produces the SCL waveform and the timing strobes for a single-master I2C engine. It divides the functional clock by a power of two, given as a 3-bit exponent, into prescaled cycles. Four separate counts, all measured in prescaled cycles, then set the timing: the SCL high time, the SCL low time, the setup and hold time around START and STOP conditions, and the point in the low phase where SDA may change. The engine sends one command at a time: a START (which also serves as a repeated START), a STOP, or one data/acknowledge bit. The generator drives SCL through an open-drain pull output. It signals the engine when to move SDA, when to make the START/STOP transition, when SDA has been sampled, and when the command is finished.

SCL and SDA come back through two-flop synchronisers. The high phase, and the setup interval before a STOP or a repeated START, count only prescaled cycles on which SCL is seen high. A slave that stretches the clock therefore lengthens the phase and does not shorten it. A separate detector flags a pin held low for too long. Software computes the counts, and they may change only while the enable input is low.

Top module: `i2c_scl_timing`

## Requirements
- R1: Commands are coded on `req_cmd` as 01 = START, 10 = STOP, 11 = BIT, 00 = none. `req_ready` is high only while enabled and either idle (bus free, SCL released) or owning the bus (SCL held low between commands). A command is taken on a clock edge where `req` and `req_ready` are both high. When idle, only START has an effect: BIT or STOP leaves SCL released and raises no strobe.
- R2: One prescaled cycle is 2^`presc_exp` functional clocks (exponent 0 to 7). The prescaler restarts on the edge that takes a command, so each phase lasts a whole number of prescaled cycles from that edge.
- R3: For a BIT, SCL stays pulled for (`t_low`+1) prescaled cycles after the taking edge and is then released.
- R4: `dv_stb` pulses for one clock, one clock after the (`t_dv`+1)-th prescaled cycle of the low phase, during BIT, STOP and repeated START; `t_dv` must not exceed `t_low`.
- R5: The high phase ends after `t_high`+1 prescaled cycles on which the synchronised SCL is high. If SCL rises S clocks after release, the release lasts (ceil((S+3)/D)+`t_high`)·D clocks, where D = 2^`presc_exp`.
- R6: At the end of the high phase, `samp_stb` and `done_stb` pulse in the same cycle that SCL is pulled again. `samp_bit` then holds the synchronised SDA level seen on the last high cycle.
- R7: A START from idle waits (`t_sh`+1) prescaled cycles with SCL high, pulses `edge_stb`, waits (`t_sh`+1) more, then pulls SCL and pulses `done_stb`. The bus is then owned.
- R8: A STOP from the owned state runs a low phase, releases SCL, waits (`t_sh`+1) SCL-high prescaled cycles, pulses `edge_stb`, waits (`t_sh`+1) more, and pulses `done_stb`. It leaves SCL released and the block idle.
- R9: A START from the owned state (repeated START) runs the same sequence as STOP, but pulls SCL at the end and stays owned.
- R10: When `plt_limit` is non-zero, `plt_stb` pulses once when SCL or SDA (synchronised) has been low for more than `plt_limit`·D consecutive clocks. It rearms only after both lines are high again. Zero disables it.
- R11: While `en` is low, SCL is released, `req_ready` is low and the sequence returns to idle.
- R12: After reset, SCL is released, every strobe is low and `req_ready` is high when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable; counts may change only while low |
| presc_exp | input | PW (3) | Prescaler exponent |
| t_high | input | CW (6) | High-phase count |
| t_low | input | CW (6) | Low-phase count |
| t_sh | input | CW (6) | START/STOP setup and hold count |
| t_dv | input | CW (6) | Data-valid delay count |
| plt_limit | input | TW (12) | Pin-low timeout, prescaled cycles; 0 disables |
| req | input | 1 | Command request |
| req_cmd | input | 2 | Command code |
| req_ready | output | 1 | Command can be taken this cycle |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| dv_stb | output | 1 | SDA may change now |
| edge_stb | output | 1 | Make the START/STOP SDA transition now |
| samp_stb | output | 1 | SDA sampled |
| samp_bit | output | 1 | Sampled SDA level |
| done_stb | output | 1 | Command finished |
| plt_stb | output | 1 | Pin-low timeout |

## Verification
BIT timing is tried over a table of prescaler exponents 0 to 3, with count sets that range from all-zero to unequal high and low values. Some rows include slave stretching of several clocks. This separates the prescaler scaling from the low count, the data-valid offset from the low count, and the sync term from the stretch term, since each row moves a different factor of the expected lengths. Directed runs cover START from idle, repeated START and STOP, which differ only in where they start and end. They also cover BIT and STOP sent while idle, disable in mid-bit, and a held-low SDA against the timeout.

// File: rtl/i2c_tgen_pkg.sv
// Shared types of the SCL timing generator: command codes and sequencer states.
package i2c_tgen_pkg;
    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_START = 2'b01,
        CMD_STOP  = 2'b10,
        CMD_BIT   = 2'b11
    } tg_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OWN, ST_LOW, ST_HIGH, ST_SETUP, ST_HOLD
    } tg_state_e;
endpackage

// File: rtl/i2c_tgen_sync.sv
// Multi-stage synchroniser for the returned bus lines.
// Assumes idle lines are high, so every stage resets to 1.
module i2c_tgen_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // first stage captures the asynchronous lines
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '1;
        else        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // later stages shift the captured value along
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= '1;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_tgen_presc.sv
// Power-of-two prescaler: tick is high one clock in every 2^exp.
// Assumes clr is held while no phase is running, so the tick train
// restarts from the edge that starts a command.
module i2c_tgen_presc #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [PW-1:0] exp_i,
    output logic          tick
);
    localparam int PCW = (1 << PW) - 1;

    logic [PCW-1:0] pc;
    logic [PCW-1:0] wrap;

    // terminal count for the selected exponent
    always_comb wrap = ~({PCW{1'b1}} << exp_i);

    assign tick = !clr && (pc == wrap);

    // divide counter, cleared while idle
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pc <= '0;
        else if (tick)     pc <= '0;
        else               pc <= pc + 1'b1;
    end
endmodule

// File: rtl/i2c_tgen_lowwd.sv
// Pin-low timeout: counts functional clocks with either line low and
// pulses once when the run exceeds limit * 2^exp clocks.
// Assumes the line inputs are already synchronised.
module i2c_tgen_lowwd #(
    parameter int TW = 12,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] exp_i,
    input  logic [TW-1:0] limit,
    input  logic          scl_hi,
    input  logic          sda_hi,
    output logic          stb
);
    localparam int KW = TW + (1 << PW) - 1;

    logic [KW-1:0] run;
    logic [KW-1:0] lim_cyc;
    logic          lo;

    assign lo = !scl_hi || !sda_hi;

    // limit scaled to functional clocks
    always_comb lim_cyc = KW'(limit) << exp_i;

    // saturating low-run counter and one-shot strobe
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run <= '0;
            stb <= 1'b0;
        end else begin
            stb <= lo && (limit != '0) && (run == lim_cyc);
            if (!lo)             run <= '0;
            else if (run != '1)  run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_tgen_seq.sv
// Phase sequencer: walks low, high, setup and hold phases in prescaled
// ticks and drives the SCL pull and the registered strobes.
// Assumes counts are stable while enabled and t_dv <= t_low.
module i2c_tgen_seq
    import i2c_tgen_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          scl_hi,
    input  logic          sda_hi,
    input  logic [CW-1:0] t_high,
    input  logic [CW-1:0] t_low,
    input  logic [CW-1:0] t_sh,
    input  logic [CW-1:0] t_dv,
    input  logic          req,
    input  logic [1:0]    req_cmd,
    output logic          ready,
    output logic          parked,
    output logic          scl_pull,
    output logic          dv_stb,
    output logic          edge_stb,
    output logic          samp_stb,
    output logic          samp_bit,
    output logic          done_stb
);
    tg_state_e     st;
    tg_cmd_e       cmd_q;
    tg_cmd_e       cmd_in;
    logic [CW-1:0] cnt;

    assign cmd_in = tg_cmd_e'(req_cmd);
    assign parked = (st == ST_IDLE) || (st == ST_OWN);
    assign ready  = en && parked;

    // phase state machine with tick-based phase counter
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st       <= ST_IDLE;
            cmd_q    <= CMD_NONE;
            cnt      <= '0;
            scl_pull <= 1'b0;
            dv_stb   <= 1'b0;
            edge_stb <= 1'b0;
            samp_stb <= 1'b0;
            samp_bit <= 1'b1;
            done_stb <= 1'b0;
        end else begin
            dv_stb   <= 1'b0;
            edge_stb <= 1'b0;
            samp_stb <= 1'b0;
            done_stb <= 1'b0;
            case (st)
                ST_IDLE: if (req && cmd_in == CMD_START) begin
                    cmd_q <= CMD_START;
                    cnt   <= '0;
                    st    <= ST_SETUP;
                end
                ST_OWN: if (req && cmd_in != CMD_NONE) begin
                    cmd_q <= cmd_in;
                    cnt   <= '0;
                    st    <= ST_LOW;
                end
                ST_LOW: if (tick) begin
                    if (cnt == t_dv) dv_stb <= 1'b1;
                    if (cnt == t_low) begin
                        cnt      <= '0;
                        scl_pull <= 1'b0;
                        st       <= (cmd_q == CMD_BIT) ? ST_HIGH : ST_SETUP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HIGH: if (tick && scl_hi) begin
                    if (cnt == t_high) begin
                        samp_stb <= 1'b1;
                        samp_bit <= sda_hi;
                        done_stb <= 1'b1;
                        scl_pull <= 1'b1;
                        st       <= ST_OWN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SETUP: if (tick && scl_hi) begin
                    if (cnt == t_sh) begin
                        edge_stb <= 1'b1;
                        cnt      <= '0;
                        st       <= ST_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: if (tick) begin
                    if (cnt == t_sh) begin
                        done_stb <= 1'b1;
                        if (cmd_q == CMD_START) begin
                            scl_pull <= 1'b1;
                            st       <= ST_OWN;
                        end else begin
                            st       <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_scl_timing.sv
// SCL bit-timing generator top: synchroniser, prescaler, phase
// sequencer and pin-low timeout. Assumes an open-drain SCL where
// scl_pull=1 drives low, and timing inputs changed only with en low.
module i2c_scl_timing #(
    parameter int PW = 3,
    parameter int CW = 6,
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] presc_exp,
    input  logic [CW-1:0] t_high,
    input  logic [CW-1:0] t_low,
    input  logic [CW-1:0] t_sh,
    input  logic [CW-1:0] t_dv,
    input  logic [TW-1:0] plt_limit,
    input  logic          req,
    input  logic [1:0]    req_cmd,
    output logic          req_ready,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_pull,
    output logic          dv_stb,
    output logic          edge_stb,
    output logic          samp_stb,
    output logic          samp_bit,
    output logic          done_stb,
    output logic          plt_stb
);
    logic [1:0] lines;
    logic       tick;
    logic       parked;

    i2c_tgen_sync #(.W(2), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines)
    );

    i2c_tgen_presc #(.PW(PW)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr(parked || !en),
        .exp_i(presc_exp), .tick(tick)
    );

    i2c_tgen_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .scl_hi(lines[1]), .sda_hi(lines[0]),
        .t_high(t_high), .t_low(t_low), .t_sh(t_sh), .t_dv(t_dv),
        .req(req), .req_cmd(req_cmd), .ready(req_ready), .parked(parked),
        .scl_pull(scl_pull), .dv_stb(dv_stb), .edge_stb(edge_stb),
        .samp_stb(samp_stb), .samp_bit(samp_bit), .done_stb(done_stb)
    );

    i2c_tgen_lowwd #(.TW(TW), .PW(PW)) u_lowwd (
        .clk(clk), .rst_n(rst_n), .en(en), .exp_i(presc_exp),
        .limit(plt_limit), .scl_hi(lines[1]), .sda_hi(lines[0]),
        .stb(plt_stb)
    );
endmodule

// File: rtl/i2c_scl_timing_chk.sv
// Protocol checker for the SCL timing generator, bound to the top.
module i2c_scl_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic req_ready,
    input logic scl_pull,
    input logic dv_stb,
    input logic edge_stb,
    input logic samp_stb,
    input logic done_stb,
    input logic plt_stb
);
    AST_SAMPLE_ON_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb |-> (scl_pull && !$past(scl_pull) && done_stb)); // R6
    AST_DV_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        dv_stb |-> $past(scl_pull)); // R4
    AST_EDGE_SCL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_stb |-> !scl_pull); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dv_stb, edge_stb, samp_stb})); // R4
    AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !scl_pull); // R11
    AST_OFF_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !req_ready); // R1
    AST_PLT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        plt_stb |=> !plt_stb); // R10
endmodule

bind i2c_scl_timing i2c_scl_timing_chk chk_i (
    .clk(clk), .rst_n(rst_n), .en(en), .req_ready(req_ready),
    .scl_pull(scl_pull), .dv_stb(dv_stb), .edge_stb(edge_stb),
    .samp_stb(samp_stb), .done_stb(done_stb), .plt_stb(plt_stb)
);

// File: tb/i2c_scl_timing_tb.sv
// Self-checking bench for the SCL timing generator.
module i2c_scl_timing_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    // P, HIGH, LOW, DV, STRETCH, SDA, exp low clocks, exp dv position, exp high clocks
    localparam int VEC [NV][9] = '{
        '{0, 3, 6, 1, 0, 1,  7,  3,  6},
        '{1, 4, 8, 2, 0, 0, 18,  7, 12},
        '{2, 1, 3, 1, 0, 1, 16,  9,  8},
        '{0, 2, 4, 2, 5, 0,  5,  4, 10},
        '{2, 2, 4, 2, 6, 1, 20, 13, 20},
        '{3, 0, 0, 0, 0, 0,  8,  9,  8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic [2:0]  presc_exp = '0;
    logic [5:0]  t_high = 6'd2, t_low = 6'd4, t_sh = 6'd2, t_dv = 6'd1;
    logic [11:0] plt_limit = '0;
    logic        req = 1'b0;
    logic [1:0]  req_cmd = 2'b00;
    logic        req_ready, scl_pull, dv_stb, edge_stb, samp_stb, samp_bit, done_stb, plt_stb;
    logic        hold = 1'b0;
    logic        sda_drv = 1'b1;
    logic        scl_in, sda_in;

    int total = 0, bad = 0;
    bit finished = 1'b0;
    int m_low, m_high, m_dv, m_edge, m_done, m_samp, m_sbit, m_pull;

    assign scl_in = !scl_pull && !hold;
    assign sda_in = sda_drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_scl_timing dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .presc_exp(presc_exp),
        .t_high(t_high), .t_low(t_low), .t_sh(t_sh), .t_dv(t_dv),
        .plt_limit(plt_limit), .req(req), .req_cmd(req_cmd), .req_ready(req_ready),
        .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull), .dv_stb(dv_stb),
        .edge_stb(edge_stb), .samp_stb(samp_stb), .samp_bit(samp_bit),
        .done_stb(done_stb), .plt_stb(plt_stb)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic setcfg(input int p, input int hi, input int lo, input int sh, input int dv, input int plt);
        @(negedge clk); en = 1'b0;
        presc_exp = 3'(p); t_high = 6'(hi); t_low = 6'(lo); t_sh = 6'(sh); t_dv = 6'(dv);
        plt_limit = 12'(plt);
        @(negedge clk); en = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // issue one command and measure its waveform at negedges
    task automatic run_cmd(input logic [1:0] c, input int stretch);
        int hl;
        bit rel;
        @(negedge clk);
        req = 1'b1; req_cmd = c;
        hold = (stretch != 0); hl = stretch; rel = 1'b0;
        m_low = 0; m_high = 0; m_dv = 0; m_edge = 0; m_done = 0; m_samp = 0; m_sbit = 0; m_pull = 0;
        for (int n = 1; n <= 3000; n++) begin
            @(negedge clk);
            req = 1'b0;
            if (dv_stb) m_dv = n;
            if (edge_stb) m_edge = n;
            if (!scl_pull) begin
                rel = 1'b1;
                m_high++;
                if (hl == 0) hold = 1'b0;
                else hl--;
            end else if (!rel) begin
                m_low++;
            end
            if (done_stb) begin
                m_done = n; m_samp = int'(samp_stb); m_sbit = int'(samp_bit); m_pull = int'(scl_pull);
                break;
            end
        end
        hold = 1'b0;
    endtask

    initial begin
        int seen, pos;
        // R12: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "scl_pull after reset", int'(scl_pull), 0);
        chk("R12", "ready after reset", int'(req_ready), 1);
        chk("R12", "strobes after reset", int'({dv_stb, edge_stb, samp_stb, done_stb, plt_stb}), 0);

        // R2 R3 R4 R5 R6: table of bit timings
        for (int v = 0; v < NV; v++) begin
            setcfg(VEC[v][0], VEC[v][1], VEC[v][2], 2, VEC[v][3], 0);
            sda_drv = 1'b1;
            run_cmd(2'b01, 0);
            sda_drv = VEC[v][5][0];
            repeat (3) @(negedge clk);
            run_cmd(2'b11, VEC[v][4]);
            chk("R3", $sformatf("row%0d low clocks", v), m_low, VEC[v][6]);
            chk("R4", $sformatf("row%0d dv position", v), m_dv, VEC[v][7]);
            chk("R5", $sformatf("row%0d high clocks", v), m_high, VEC[v][8]);
            chk("R6", $sformatf("row%0d sample strobe", v), m_samp, 1);
            chk("R6", $sformatf("row%0d sampled bit", v), m_sbit, VEC[v][5]);
            sda_drv = 1'b1;
            repeat (3) @(negedge clk);
            run_cmd(2'b10, 0);
        end

        // R7: START from idle, D=2, t_sh=3
        setcfg(1, 2, 4, 3, 1, 0);
        run_cmd(2'b01, 0);
        chk("R7", "start edge position", m_edge, 9);
        chk("R7", "start released clocks", m_high, 16);
        chk("R7", "start done position", m_done, 17);
        chk("R7", "scl pulled at start end", m_pull, 1);

        // R9: repeated START from owned
        run_cmd(2'b01, 0);
        chk("R9", "rstart dv position", m_dv, 5);
        chk("R9", "rstart low clocks", m_low, 10);
        chk("R9", "rstart edge position", m_edge, 21);
        chk("R9", "rstart done position", m_done, 29);
        chk("R9", "scl pulled at rstart end", m_pull, 1);

        // R8: STOP from owned
        run_cmd(2'b10, 0);
        chk("R8", "stop edge position", m_edge, 21);
        chk("R8", "stop done position", m_done, 29);
        chk("R8", "scl released at stop end", m_pull, 0);
        repeat (4) @(negedge clk);
        chk("R8", "idle ready after stop", int'(req_ready), 1);

        // R1: BIT and STOP while idle are ignored
        seen = 0;
        @(negedge clk); req = 1'b1; req_cmd = 2'b11;
        @(negedge clk); req_cmd = 2'b10;
        @(negedge clk); req = 1'b0;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (scl_pull || dv_stb || edge_stb || samp_stb || done_stb) seen++;
        end
        chk("R1", "activity after idle BIT/STOP", seen, 0);

        // R11: disable in the middle of a bit
        run_cmd(2'b01, 0);
        @(negedge clk); req = 1'b1; req_cmd = 2'b11;
        @(negedge clk); req = 1'b0;
        repeat (2) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R11", "scl released when disabled", int'(scl_pull), 0);
        chk("R11", "ready low when disabled", int'(req_ready), 0);
        en = 1'b1;
        @(negedge clk);
        chk("R11", "idle after re-enable", int'(req_ready && !scl_pull), 1);

        // R10: pin-low timeout, D=2, limit 5 -> pulse at position 13
        setcfg(1, 2, 4, 3, 1, 5);
        seen = 0; pos = 0;
        sda_drv = 1'b0;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            if (plt_stb) begin seen++; pos = n; end
        end
        chk("R10", "timeout pulse count", seen, 1);
        chk("R10", "timeout pulse position", pos, 13);
        sda_drv = 1'b1;
        setcfg(1, 2, 4, 3, 1, 0);
        seen = 0;
        sda_drv = 1'b0;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            if (plt_stb) seen++;
        end
        chk("R10", "timeout disabled by zero", seen, 0);
        sda_drv = 1'b1;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule